// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Scheduler

This block is the unified scheduling window of an out-of-order core. Each cycle it can take one instruction from the dispatch side, in program order, as long as the window has room. An instruction carries a function-unit type, up to two source register numbers and an optional destination register. The block looks each source up in a rename table that holds one producer tag per architectural register. A source whose table slot is empty can be used at once. Any other source records the producer tag and waits for it. Every accepted instruction receives a fresh tag from a wrapping counter, and a destination register has its table slot overwritten with that tag.

Result buses broadcast tags of completed work. A broadcast wakes every waiting source that holds the tag. It clears the table slot of the broadcast destination only if that slot still names the broadcast tag, so a newer producer of the same register is never lost. Each entry passes through three states. An entry enters WAITING on insertion. WAITING goes to ISSUED when the entry is picked for a free unit of its type. ISSUED goes to RETIRING when its own tag is broadcast. A RETIRING entry is removed on the next clock edge. The window collapses toward slot 0, so slot order is age order and older ready entries win free units first. Operand values, completion arbitration and branch prediction are handled elsewhere.

Top module: `tag_rs_sched`

## Requirements
- R1: The window holds 2 × NTYPE × UNITS_PER_TYPE entries (12 by default). `in_ready` is low exactly when all entries are occupied. An `in_valid` presented while `in_ready` is low is ignored: no tag is consumed and nothing is inserted.
- R2: A source whose enable bit is 0 is treated as absent and is ready at once.
- R3: An enabled source whose rename-table slot is empty (tag 0) is ready at once. Otherwise the entry stores the slot's tag and waits for it.
- R4: After reset, `in_tag` shows 1. It advances by one on each accepted instruction, wraps from all-ones back to 1, and is never 0.
- R5: An accepted instruction with `in_dst_en` set overwrites the table slot of `in_dst` with its own tag.
- R6: A WAITING entry with all sources ready fires when `fu_avail` for its type is high. `fire_vld[t]` and `fire_tag[t]` show it combinationally in that cycle. At most one entry fires per type per cycle, nothing fires while the type's `fu_avail` is low, and an entry that has fired never fires again.
- R7: Among ready entries of the same type, the oldest in program order fires first.
- R8: A broadcast tag marks every matching waiting source as ready, and the entry can fire in the following cycle. This includes an instruction inserted in the same cycle as the broadcast of its producer tag.
- R9: A broadcast with `bc_dst_en` set clears the table slot of `bc_dst` only if that slot equals the broadcast tag.
- R10: An entry whose own tag is broadcast keeps its slot for the cycle after the broadcast and is removed at the following edge.
- R11: Reset empties the window and sets every rename-table slot to 0 (no tag). After reset `in_ready` is 1 and no `fire_vld` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Dispatch offers an instruction |
| in_ready | output | 1 | Window has a free entry |
| in_type | input | TYPE_W | Function-unit type of the offered instruction |
| in_src_a_en | input | 1 | First source present |
| in_src_a | input | REG_W | First source register |
| in_src_b_en | input | 1 | Second source present |
| in_src_b | input | REG_W | Second source register |
| in_dst_en | input | 1 | Destination present |
| in_dst | input | REG_W | Destination register |
| in_tag | output | TAG_W | Tag the next accepted instruction receives |
| fu_avail | input | NTYPE | A unit of each type can take work this cycle |
| fire_vld | output | NTYPE | An entry of each type fires this cycle |
| fire_tag | output | NTYPE×TAG_W | Tag of the fired entry, one field per type |
| bc_vld | input | NBUS | Result bus carries a tag |
| bc_tag | input | NBUS×TAG_W | Broadcast tags, one field per bus |
| bc_dst_en | input | NBUS | Broadcast result writes a register |
| bc_dst | input | NBUS×REG_W | Destination register per bus |

## Verification
The embedded properties check on every cycle that occupancy never exceeds the window size and never grows while `in_ready` is low. They also check that a type fires only when a unit of that type is free, that the tag counter is never zero and moves only on acceptance, and that a broadcast naming a superseded producer leaves the rename slot alone. Operand wakeup chains, oldest-first selection, the same-cycle insertion bypass, the one-cycle retiring delay, counter wraparound and the cleared table after reset all depend on sequences of instructions. Only the bench scenarios can show them, by observing fire outputs, `in_ready` and `in_tag`.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;

    // Lifecycle of one window entry.
    typedef enum logic [1:0] {
        ES_WAIT   = 2'd0,
        ES_ISSUED = 2'd1,
        ES_DONE   = 2'd2
    } ent_state_e;

    localparam int NSRC = 2;

endpackage

// File: rtl/rs_tag_alloc.sv
module rs_tag_alloc #(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [TAG_W-1:0] cur_tag
);

    localparam logic [TAG_W-1:0] TAG_FIRST = TAG_W'(1);
    localparam logic [TAG_W-1:0] TAG_LAST  = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_tag <= TAG_FIRST;
        end else if (adv) begin
            cur_tag <= (cur_tag == TAG_LAST) ? TAG_FIRST : cur_tag + TAG_W'(1);
        end
    end

    // R4: zero is reserved for "no tag"
    a_r4_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_tag != '0);

    // R4: the counter moves only when an instruction is taken
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cur_tag));

endmodule

// File: rtl/rs_tag_table.sv
module rs_tag_table #(
    parameter int NREG  = 128,
    parameter int TAG_W = 8,
    parameter int NBUS  = 2,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_W-1:0]      rd_a_reg,
    input  logic [REG_W-1:0]      rd_b_reg,
    output logic [TAG_W-1:0]      rd_a_tag,
    output logic [TAG_W-1:0]      rd_b_tag,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_reg,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [NBUS-1:0]       bc_vld,
    input  logic [NBUS-1:0]       bc_dst_en,
    input  logic [NBUS*TAG_W-1:0] bc_tag,
    input  logic [NBUS*REG_W-1:0] bc_dst
);

    logic [TAG_W-1:0] slot [NREG];

    assign rd_a_tag = slot[rd_a_reg];
    assign rd_b_tag = slot[rd_b_reg];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                slot[r] <= '0;
            end
        end else begin
            for (int b = 0; b < NBUS; b++) begin
                if (bc_vld[b] && bc_dst_en[b] &&
                    slot[bc_dst[b*REG_W +: REG_W]] == bc_tag[b*TAG_W +: TAG_W]) begin
                    slot[bc_dst[b*REG_W +: REG_W]] <= '0;
                end
            end
            // A new producer always overrides a clear in the same cycle.
            if (wr_en) begin
                slot[wr_reg] <= wr_tag;
            end
        end
    end

    // Checker support: bus 0 names a register whose slot holds some other tag
    logic [REG_W-1:0] chk_reg;
    logic             chk_keep;
    assign chk_reg = bc_dst[REG_W-1:0];

    always_comb begin
        chk_keep = bc_vld[0] && bc_dst_en[0] && !(wr_en && wr_reg == chk_reg);
        for (int b = 0; b < NBUS; b++) begin
            if (bc_vld[b] && bc_tag[b*TAG_W +: TAG_W] == slot[chk_reg]) begin
                chk_keep = 1'b0;
            end
        end
    end

    // R9: a stale broadcast leaves a newer producer in place
    a_r9_keep_newer: assert property (@(posedge clk) disable iff (!rst_n)
        chk_keep |=> slot[$past(chk_reg)] == $past(slot[chk_reg]));

endmodule

// File: rtl/rs_fire_pick.sv
module rs_fire_pick #(
    parameter int DEPTH  = 12,
    parameter int NTYPE  = 3,
    parameter int TYPE_W = 2,
    parameter int IDX_W  = 4
) (
    input  logic [DEPTH-1:0]  cand,
    input  logic [TYPE_W-1:0] ent_type [DEPTH],
    input  logic [NTYPE-1:0]  fu_avail,
    output logic [NTYPE-1:0]  sel_vld,
    output logic [IDX_W-1:0]  sel_idx [NTYPE]
);

    for (genvar t = 0; t < NTYPE; t++) begin : g_type
        logic             hit;
        logic [IDX_W-1:0] idx;

        // Scan from the youngest slot down so the oldest match is kept.
        always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (cand[i] && fu_avail[t] && ent_type[i] == TYPE_W'(t)) begin
                    hit = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end

        assign sel_vld[t] = hit;
        assign sel_idx[t] = idx;
    end

endmodule

// File: rtl/tag_rs_sched.sv
module tag_rs_sched
    import rs_sched_pkg::*;
#(
    parameter int NTYPE          = 3,
    parameter int UNITS_PER_TYPE = 2,
    parameter int NREG           = 128,
    parameter int NBUS           = 2,
    parameter int TAG_W          = 8,
    parameter int TYPE_W         = $clog2(NTYPE),
    parameter int REG_W          = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [TYPE_W-1:0]      in_type,
    input  logic                   in_src_a_en,
    input  logic [REG_W-1:0]       in_src_a,
    input  logic                   in_src_b_en,
    input  logic [REG_W-1:0]       in_src_b,
    input  logic                   in_dst_en,
    input  logic [REG_W-1:0]       in_dst,
    output logic [TAG_W-1:0]       in_tag,
    input  logic [NTYPE-1:0]       fu_avail,
    output logic [NTYPE-1:0]       fire_vld,
    output logic [NTYPE*TAG_W-1:0] fire_tag,
    input  logic [NBUS-1:0]        bc_vld,
    input  logic [NBUS*TAG_W-1:0]  bc_tag,
    input  logic [NBUS-1:0]        bc_dst_en,
    input  logic [NBUS*REG_W-1:0]  bc_dst
);

    localparam int DEPTH = 2 * NTYPE * UNITS_PER_TYPE;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ent_state_e                  st;
        logic [TYPE_W-1:0]           fu;
        logic [TAG_W-1:0]            tag;
        logic [NSRC-1:0][TAG_W-1:0]  wtag;
        logic [NSRC-1:0]             rdy;
    } ent_t;

    ent_t             win     [DEPTH];
    ent_t             win_nxt [DEPTH];
    ent_t             new_ent;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] occ_nxt;
    logic             accept;

    logic [TAG_W-1:0] rd_a_tag;
    logic [TAG_W-1:0] rd_b_tag;
    logic [TAG_W-1:0] cur_tag;

    logic [DEPTH-1:0]  cand;
    logic [DEPTH-1:0]  issue_hit;
    logic [DEPTH-1:0]  own_hit;
    logic [TYPE_W-1:0] ent_type [DEPTH];
    logic [NTYPE-1:0]  sel_vld;
    logic [IDX_W-1:0]  sel_idx [NTYPE];

    assign in_ready = occ < CNT_W'(DEPTH);
    assign accept   = in_valid && in_ready;
    assign in_tag   = cur_tag;

    rs_tag_alloc #(
        .TAG_W (TAG_W)
    ) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (accept),
        .cur_tag (cur_tag)
    );

    rs_tag_table #(
        .NREG  (NREG),
        .TAG_W (TAG_W),
        .NBUS  (NBUS),
        .REG_W (REG_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_reg  (in_src_a),
        .rd_b_reg  (in_src_b),
        .rd_a_tag  (rd_a_tag),
        .rd_b_tag  (rd_b_tag),
        .wr_en     (accept && in_dst_en),
        .wr_reg    (in_dst),
        .wr_tag    (cur_tag),
        .bc_vld    (bc_vld),
        .bc_dst_en (bc_dst_en),
        .bc_tag    (bc_tag),
        .bc_dst    (bc_dst)
    );

    // Build the entry for the incoming instruction, with a bypass for a
    // producer tag that is broadcast in the same cycle.
    always_comb begin
        logic a_bus;
        logic b_bus;
        a_bus = 1'b0;
        b_bus = 1'b0;
        for (int b = 0; b < NBUS; b++) begin
            if (bc_vld[b] && bc_tag[b*TAG_W +: TAG_W] == rd_a_tag) a_bus = 1'b1;
            if (bc_vld[b] && bc_tag[b*TAG_W +: TAG_W] == rd_b_tag) b_bus = 1'b1;
        end
        new_ent         = '0;
        new_ent.st      = ES_WAIT;
        new_ent.fu      = in_type;
        new_ent.tag     = cur_tag;
        new_ent.wtag[0] = in_src_a_en ? rd_a_tag : '0;
        new_ent.wtag[1] = in_src_b_en ? rd_b_tag : '0;
        new_ent.rdy[0]  = !in_src_a_en || (rd_a_tag == '0) || a_bus;
        new_ent.rdy[1]  = !in_src_b_en || (rd_b_tag == '0) || b_bus;
    end

    // Per-slot decode: fire candidates and own-tag broadcast hits
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_type[i] = win[i].fu;
            cand[i]     = (i < int'(occ)) && (win[i].st == ES_WAIT) && (&win[i].rdy);
            own_hit[i]  = 1'b0;
            issue_hit[i] = 1'b0;
            for (int b = 0; b < NBUS; b++) begin
                if (bc_vld[b] && bc_tag[b*TAG_W +: TAG_W] == win[i].tag) own_hit[i] = 1'b1;
            end
            for (int t = 0; t < NTYPE; t++) begin
                if (sel_vld[t] && sel_idx[t] == IDX_W'(i)) issue_hit[i] = 1'b1;
            end
        end
    end

    rs_fire_pick #(
        .DEPTH  (DEPTH),
        .NTYPE  (NTYPE),
        .TYPE_W (TYPE_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .cand     (cand),
        .ent_type (ent_type),
        .fu_avail (fu_avail),
        .sel_vld  (sel_vld),
        .sel_idx  (sel_idx)
    );

    // Output process: one fire port per unit type
    always_comb begin
        for (int t = 0; t < NTYPE; t++) begin
            fire_vld[t]                    = sel_vld[t];
            fire_tag[t*TAG_W +: TAG_W]     = sel_vld[t] ? win[sel_idx[t]].tag : '0;
        end
    end

    // Next-state process: entry transitions, wakeup, collapse, append
    always_comb begin
        ent_t             e;
        logic [CNT_W-1:0] k;
        for (int i = 0; i < DEPTH; i++) begin
            win_nxt[i] = '0;
        end
        k = '0;
        for (int i = 0; i < DEPTH; i++) begin
            e = win[i];
            if (i < int'(occ)) begin
                for (int s = 0; s < NSRC; s++) begin
                    for (int b = 0; b < NBUS; b++) begin
                        if (bc_vld[b] && !e.rdy[s] && e.wtag[s] == bc_tag[b*TAG_W +: TAG_W]) begin
                            e.rdy[s] = 1'b1;
                        end
                    end
                end
                unique case (win[i].st)
                    ES_WAIT:   if (issue_hit[i]) e.st = ES_ISSUED;
                    ES_ISSUED: if (own_hit[i])   e.st = ES_DONE;
                    ES_DONE:   e.st = ES_DONE;
                    default:   e.st = ES_WAIT;
                endcase
                if (win[i].st != ES_DONE) begin
                    win_nxt[k[IDX_W-1:0]] = e;
                    k = k + CNT_W'(1);
                end
            end
        end
        if (accept && k < CNT_W'(DEPTH)) begin
            win_nxt[k[IDX_W-1:0]] = new_ent;
            k = k + CNT_W'(1);
        end
        occ_nxt = k;
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                win[i] <= '0;
            end
        end else begin
            occ <= occ_nxt;
            for (int i = 0; i < DEPTH; i++) begin
                win[i] <= win_nxt[i];
            end
        end
    end

    // R1: occupancy bounded by the window size
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R1: a full window never grows
    a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> occ <= $past(occ));

    for (genvar t = 0; t < NTYPE; t++) begin : g_chk
        // R6: a type only fires into a free unit
        a_r6_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
            fire_vld[t] |-> fu_avail[t]);
    end

endmodule

// File: tb/tag_rs_sched_test.sv
module tag_rs_sched_test;

    localparam int NT = 3;
    localparam int TW = 4;
    localparam int RW = 7;
    localparam int NB = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_type = '0;
    logic              in_src_a_en = 1'b0;
    logic [RW-1:0]     in_src_a = '0;
    logic              in_src_b_en = 1'b0;
    logic [RW-1:0]     in_src_b = '0;
    logic              in_dst_en = 1'b0;
    logic [RW-1:0]     in_dst = '0;
    logic [TW-1:0]     in_tag;
    logic [NT-1:0]     fu_avail = '0;
    logic [NT-1:0]     fire_vld;
    logic [NT*TW-1:0]  fire_tag;
    logic [NB-1:0]     bc_vld = '0;
    logic [NB*TW-1:0]  bc_tag = '0;
    logic [NB-1:0]     bc_dst_en = '0;
    logic [NB*RW-1:0]  bc_dst = '0;

    always #4 clk = ~clk;

    tag_rs_sched #(.TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_src_a_en(in_src_a_en), .in_src_a(in_src_a),
        .in_src_b_en(in_src_b_en), .in_src_b(in_src_b), .in_dst_en(in_dst_en),
        .in_dst(in_dst), .in_tag(in_tag), .fu_avail(fu_avail), .fire_vld(fire_vld),
        .fire_tag(fire_tag), .bc_vld(bc_vld), .bc_tag(bc_tag),
        .bc_dst_en(bc_dst_en), .bc_dst(bc_dst)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int exp_tag = 1;

    typedef struct packed {
        logic [1:0] fu;
        logic       a_en;
        logic [6:0] a;
        logic       b_en;
        logic [6:0] b;
        logic       d_en;
        logic [6:0] d;
        logic       fire;
    } vec_t;

    // Instruction vectors into a fresh window; fire = expected to issue at once
    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b0, 7'd0,  1'b0, 7'd0, 1'b1, 7'd3, 1'b1},  // R2: no sources
        '{2'd1, 1'b1, 7'd3,  1'b0, 7'd0, 1'b1, 7'd4, 1'b0},  // R3: r3 tagged
        '{2'd2, 1'b1, 7'd10, 1'b0, 7'd0, 1'b0, 7'd0, 1'b1},  // R3: r10 untagged
        '{2'd0, 1'b0, 7'd0,  1'b1, 7'd4, 1'b0, 7'd0, 1'b0},  // R3: r4 tagged
        '{2'd1, 1'b1, 7'd3,  1'b1, 7'd4, 1'b0, 7'd0, 1'b0},  // R3: both tagged
        '{2'd2, 1'b0, 7'd0,  1'b0, 7'd0, 1'b1, 7'd4, 1'b1}   // R5: r4 renamed
    };

    function automatic int nxt(input int t);
        return (t == (1 << TW) - 1) ? 1 : t + 1;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_in(input int fu, input bit ae, input int a,
                            input bit be, input int b, input bit de, input int d);
        in_valid    = 1'b1;
        in_type     = 2'(fu);
        in_src_a_en = ae;
        in_src_a    = RW'(a);
        in_src_b_en = be;
        in_src_b    = RW'(b);
        in_dst_en   = de;
        in_dst      = RW'(d);
    endtask

    task automatic push(input int fu, input bit ae, input int a,
                        input bit be, input int b, input bit de, input int d);
        drive_in(fu, ae, a, be, b, de, d);
        step();
        in_valid = 1'b0;
        exp_tag  = nxt(exp_tag);
    endtask

    task automatic set_bc(input int tag, input bit de, input int reg_n);
        bc_vld    = 2'b01;
        bc_tag    = '0;
        bc_tag[TW-1:0] = TW'(tag);
        bc_dst_en = {1'b0, de};
        bc_dst    = '0;
        bc_dst[RW-1:0] = RW'(reg_n);
    endtask

    task automatic clr_bc;
        bc_vld    = '0;
        bc_dst_en = '0;
    endtask

    task automatic bcast(input int tag, input bit de, input int reg_n);
        set_bc(tag, de, reg_n);
        step();
        clr_bc();
    endtask

    task automatic fire_chk(input string what, input int fu, input int vld, input int tag);
        fu_avail = '1;
        #1;
        chk({what, " fire_vld"}, int'(fire_vld[fu]), vld);
        if (vld != 0) chk({what, " fire_tag"}, int'(fire_tag[fu*TW +: TW]), tag);
        step();
        fu_avail = '0;
    endtask

    task automatic do_reset;
        in_valid = 1'b0;
        fu_avail = '0;
        clr_bc();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        exp_tag = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R11: reset state
        fu_avail = '1;
        #1;
        chk("R11 in_ready after reset", int'(in_ready), 1);
        chk("R11 no fire after reset", int'(fire_vld), 0);
        chk("R4 first tag", int'(in_tag), 1);
        fu_avail = '0;

        // Vector table walk
        for (int i = 0; i < 6; i++) begin
            int tg;
            tg = exp_tag;
            chk("R4 tag sequence", int'(in_tag), tg);
            push(VEC[i].fu, VEC[i].a_en, VEC[i].a, VEC[i].b_en, VEC[i].b,
                 VEC[i].d_en, VEC[i].d);
            fire_chk("R2/R3/R5 vector", VEC[i].fu, VEC[i].fire, tg);
        end

        // R8: tag 1 wakes the type-1 entry waiting on r3
        bcast(1, 1'b1, 3);
        fire_chk("R8 wakeup", 1, 1, 2);

        // R9/R5: tag 2 names r4 which now holds tag 6, so r4 keeps it
        bcast(2, 1'b1, 4);
        #1;
        chk("R6 no fire without free unit", int'(fire_vld), 0);
        fu_avail = '1;
        #1;
        chk("R8 second wakeup type0", int'(fire_tag[0 +: TW]), 4);
        chk("R8 second wakeup type1", int'(fire_tag[TW +: TW]), 5);
        chk("R6 one per type, none ready type2", int'(fire_vld), 3);
        step();
        fu_avail = '0;

        push(1, 1'b1, 4, 1'b0, 0, 1'b0, 0);                 // tag 7 waits on 6
        fire_chk("R9 stale broadcast kept r4 renamed (R5)", 1, 0, 0);
        bcast(6, 1'b1, 4);
        fire_chk("R9 matching broadcast wakes", 1, 1, 7);

        // R8 bypass: producer broadcast in the insertion cycle
        push(0, 1'b0, 0, 1'b0, 0, 1'b1, 20);                // tag 8
        fire_chk("R8 producer", 0, 1, 8);
        drive_in(2, 1'b1, 20, 1'b0, 0, 1'b0, 0);            // tag 9
        set_bc(8, 1'b1, 20);
        step();
        in_valid = 1'b0;
        clr_bc();
        exp_tag = nxt(exp_tag);
        fire_chk("R8 same-cycle bypass", 2, 1, 9);

        // R7: oldest first, then R6 no refire
        push(1, 1'b0, 0, 1'b0, 0, 1'b0, 0);                 // tag 10
        push(1, 1'b0, 0, 1'b0, 0, 1'b0, 0);                 // tag 11
        fu_avail = 3'b010;
        #1;
        chk("R7 oldest wins", int'(fire_tag[TW +: TW]), 10);
        step();
        #1;
        chk("R6 fired entry not refired", int'(fire_tag[TW +: TW]), 11);
        step();
        fu_avail = '0;

        // Tag r50, then reset and show it is clear (R11)
        push(0, 1'b0, 0, 1'b0, 0, 1'b1, 50);
        do_reset();

        // R1: fill the window
        push(0, 1'b1, 50, 1'b0, 0, 1'b0, 0);                // tag 1, reads r50
        for (int i = 0; i < 11; i++) begin
            push(0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
        end
        chk("R1 full at twelve entries", int'(in_ready), 0);
        drive_in(0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
        step();
        in_valid = 1'b0;
        chk("R1 offer ignored when full (tag)", int'(in_tag), 13);
        chk("R1 offer ignored when full (ready)", int'(in_ready), 0);
        fu_avail = 3'b001;
        #1;
        chk("R11 r50 cleared by reset, entry fires", int'(fire_tag[0 +: TW]), 1);
        step();
        fu_avail = '0;
        bcast(1, 1'b0, 0);
        chk("R10 entry held one cycle after broadcast", int'(in_ready), 0);
        step();
        chk("R10 entry removed after hold", int'(in_ready), 1);

        // R4: wraparound
        do_reset();
        for (int i = 1; i < (1 << TW); i++) begin
            chk("R4 tag counts up", int'(in_tag), i);
            push(0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
            fu_avail = 3'b001;
            step();
            fu_avail = '0;
            bcast(i, 1'b0, 0);
            step();
        end
        chk("R4 wrap to one", int'(in_tag), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule